// File: doc/BRIEF.md
# Bitplane Fine Scroll Delay Loader

This block sits between the per-plane data-word registers and the per-plane 16-bit output shift registers of a planar video serializer. The bus writes words into the plane data registers. A write to the first plane's register is the trigger: it takes a snapshot of every plane's register into a holding stage and arms a pending flag for each of the two plane groups. One group holds the odd-numbered planes and the other the even-numbered planes.

Each group has its own 4-bit fine-scroll delay. The low four bits of the horizontal pixel counter are compared with that delay on every pixel clock. When they match and the group's flag is armed, the held words are moved into that group's shift registers and the flag is cleared. The delay is therefore not applied once per line. A delay change in the middle of a line can make a transfer come late or never. The shifters then run dry and emit zeros, which gives the tearing that real hardware shows. Playfield and colour modes play no part here.

The shift registers emit one bit per plane per pixel clock, most significant bit first. Until the first trigger on a line, every output is held at zero so that only background colour is shown.

Top module: `bpl_scroll_loader`

## Requirements
- R1: After synchronous active-low reset, all pixel outputs are 0, both pending flags are clear and the outputs are blanked.
- R2: A write with `wr_sel` = 0 (plane 1) copies every plane's data register into the holding stage. Plane 1's slot takes the value written in that cycle. A write to any other plane changes only that plane's data register: the holding stage and the pending flags keep their values.
- R3: A write with `wr_sel` = 0 arms the pending flags of both groups.
- R4: At the clock edge where `hpos_lo` equals a group's delay and that group's flag is armed, the held words load into the group's shift registers and the flag clears. Bit 15 of each loaded word appears on `pix_out` in the following cycle.
- R5: Plane indices 0, 2 and 4 (bits of `pix_out`) form the odd group and use `dly_odd`. Indices 1, 3 and 5 form the even group and use `dly_even`. The two groups transfer independently.
- R6: Each shift register outputs bit 15 first and shifts left by one bit per clock, filling with zeros. After 16 shifts without a load it outputs 0.
- R7: `line_start` blanks `pix_out` to 0 from the next cycle. A write with `wr_sel` = 0 unblanks the outputs from the next cycle, and the write wins when both occur in the same cycle.
- R8: While no match occurs, an armed group keeps its held words. Its shifters drain to zeros, and a later match loads the unchanged held words.
- R9: A plane-1 write in the same cycle as a delay match transfers the newly captured words at that same edge, and the flag ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | Start-of-line pulse; blanks the outputs |
| wr_en | input | 1 | Data register write strobe |
| wr_sel | input | 3 | Plane index being written (0 = plane 1, the trigger) |
| wr_data | input | 16 | Word being written |
| hpos_lo | input | 4 | Low four bits of the horizontal pixel counter |
| dly_odd | input | 4 | Fine-scroll delay for the odd group |
| dly_even | input | 4 | Fine-scroll delay for the even group |
| pix_out | output | 6 | One serial pixel bit per plane |

## Verification
The assertions assume at most one register write per cycle, and a `wr_sel` that always names an existing plane. They make no assumption about the delays or the counter, so either may change on any cycle. The bench keeps every write index within range and steps the counter by one per clock. It also moves the delays freely in the middle of a line, and in one case re-targets them every cycle so that a match is avoided on purpose.

// File: rtl/bpl_scroll_pkg.sv
// Shared constants and types for the fine-scroll loader.
// Assumes two plane groups (odd/even) and 16-bit plane words.
package bpl_scroll_pkg;
    localparam int WORD_W = 16;
    localparam int GROUPS = 2;
    typedef logic [WORD_W-1:0] word_t;

    // Group a plane index belongs to: 0 = odd planes, 1 = even planes.
    function automatic int grp_of(input int plane_idx);
        return plane_idx % GROUPS;
    endfunction
endpackage

// File: rtl/bpl_word_capture.sv
// Plane data registers plus the holding stage.
// A write to plane index 0 snapshots all planes into the holding stage.
// Exports the holding values as the shifters would see them this cycle,
// so a load can happen on the same edge as the trigger.
// Assumes at most one write per cycle and wr_sel < NUM_PLANES.
module bpl_word_capture
    import bpl_scroll_pkg::*;
#(
    parameter int NUM_PLANES = 6,
    parameter int SEL_W      = $clog2(NUM_PLANES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [SEL_W-1:0]                  wr_sel,
    input  word_t                             wr_data,
    output logic                              trig,
    output logic [NUM_PLANES-1:0][WORD_W-1:0] hold_eff
);
    logic [NUM_PLANES-1:0][WORD_W-1:0] data_q;
    logic [NUM_PLANES-1:0][WORD_W-1:0] hold_q;

    // Trigger: a write to the first plane's register.
    always_comb trig = wr_en && (wr_sel == '0);

    for (genvar i = 0; i < NUM_PLANES; i++) begin : g_plane
        // Holding value seen this cycle, bypassing a trigger in flight.
        if (i == 0) begin : g_first
            always_comb hold_eff[i] = trig ? wr_data : hold_q[i];
        end else begin : g_rest
            always_comb hold_eff[i] = trig ? data_q[i] : hold_q[i];
        end

        // Per-plane data register written by the bus.
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[i] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(i)))
                data_q[i] <= wr_data;
        end

        // Holding register updated only by the trigger.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_q[i] <= '0;
            else
                hold_q[i] <= hold_eff[i];
        end
    end

    // Holding stage moves only on a trigger write.
    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> (hold_q == $past(hold_q)));

    // Selected plane must exist.
    assert_sel_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_sel) < NUM_PLANES));
endmodule

// File: rtl/bpl_group_ctl.sv
// Pending flag and delay comparator for one plane group.
// Compares the masked pixel counter with the group delay every cycle.
// Raises load on a match while armed (or armed this cycle).
// Assumes the delay may change on any cycle.
module bpl_group_ctl #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] hpos_lo,
    input  logic [CNT_W-1:0] delay,
    input  logic             trig,
    output logic             load,
    output logic             pend
);
    logic match;

    // Continuous position comparison.
    always_comb match = (hpos_lo == delay);
    // Transfer when matched and armed; a same-cycle trigger counts as armed.
    always_comb load  = match && (pend || trig);

    // Pending flag: a load clears it, a trigger arms it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (load)
            pend <= 1'b0;
        else if (trig)
            pend <= 1'b1;
    end

    assert_pend_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && (hpos_lo != delay)) |=> pend);

    assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !pend);

    assert_pend_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && (hpos_lo != delay)) |=> pend);
endmodule

// File: rtl/bpl_plane_shifter.sv
// Output shift register for one plane.
// Loads a word on load, otherwise shifts left one bit, zero fill.
// The serial bit is the register's MSB.
module bpl_plane_shifter
    import bpl_scroll_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  word_t din,
    output logic  msb
);
    word_t sreg;

    // Load or shift one position toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg <= '0;
        else if (load)
            sreg <= din;
        else
            sreg <= {sreg[WORD_W-2:0], 1'b0};
    end

    // Serial output.
    always_comb msb = sreg[WORD_W-1];

    assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (sreg == '0)) |=> (sreg == '0));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (msb == $past(din[WORD_W-1])));
endmodule

// File: rtl/bpl_scroll_loader.sv
// Top of the fine-scroll delay loader.
// Captures plane words, arms per-group transfers and serializes one
// bit per plane per clock. Even-indexed planes form the odd group
// (dly_odd); odd-indexed planes form the even group (dly_even).
// Outputs stay blank from line_start until the next plane-1 write.
module bpl_scroll_loader
    import bpl_scroll_pkg::*;
#(
    parameter int NUM_PLANES = 6,
    parameter int CNT_W      = 4,
    localparam int SEL_W     = $clog2(NUM_PLANES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_start,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [CNT_W-1:0]      hpos_lo,
    input  logic [CNT_W-1:0]      dly_odd,
    input  logic [CNT_W-1:0]      dly_even,
    output logic [NUM_PLANES-1:0] pix_out
);
    logic                              trig;
    logic [NUM_PLANES-1:0][WORD_W-1:0] hold_eff;
    logic [GROUPS-1:0]                 grp_load;
    logic [GROUPS-1:0]                 grp_pend;
    logic [NUM_PLANES-1:0]             msb;
    logic                              en_q;

    bpl_word_capture #(.NUM_PLANES(NUM_PLANES), .SEL_W(SEL_W)) cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .trig     (trig),
        .hold_eff (hold_eff)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [CNT_W-1:0] dly;
        // Group delay select.
        always_comb dly = (g == 0) ? dly_odd : dly_even;

        bpl_group_ctl #(.CNT_W(CNT_W)) ctl_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .hpos_lo (hpos_lo),
            .delay   (dly),
            .trig    (trig),
            .load    (grp_load[g]),
            .pend    (grp_pend[g])
        );
    end

    for (genvar i = 0; i < NUM_PLANES; i++) begin : g_shf
        bpl_plane_shifter shf_i (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (grp_load[grp_of(i)]),
            .din   (hold_eff[i]),
            .msb   (msb[i])
        );
    end

    // Line enable: trigger unblanks, line start blanks; trigger wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (trig)
            en_q <= 1'b1;
        else if (line_start)
            en_q <= 1'b0;
    end

    // Blanked serial outputs.
    always_comb pix_out = en_q ? msb : '0;

    assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !trig) |=> (pix_out == '0));

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> ((pix_out == '0) && (grp_pend == '0)));
endmodule

// File: tb/bpl_scroll_loader_tb_top.sv
module bpl_scroll_loader_tb_top;
    localparam int NP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  hpos_lo = '0;
    logic [3:0]  dly_odd = '0;
    logic [3:0]  dly_even = '0;
    logic [NP-1:0] pix_out;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // Reference state from the requirements.
    logic [15:0] m_d [NP];
    logic [15:0] m_h [NP];
    logic [15:0] m_s [NP];
    logic        m_p [2];
    logic        m_en;

    always #2 clk = ~clk;

    bpl_scroll_loader dut_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .hpos_lo(hpos_lo), .dly_odd(dly_odd), .dly_even(dly_even),
        .pix_out(pix_out)
    );

    task automatic check(input string t, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pix_out actual %b expected %b at %0t", t, act, exp, $time);
        end
    endtask

    // One clock: model next state from current inputs, then compare.
    task automatic step();
        logic [15:0] he [NP];
        logic        ld [2];
        logic        trig;
        logic [NP-1:0] exp;
        trig = wr_en && (wr_sel == 3'd0);
        for (int i = 0; i < NP; i++)
            he[i] = trig ? ((i == 0) ? wr_data : m_d[i]) : m_h[i];
        for (int g = 0; g < 2; g++)
            ld[g] = (hpos_lo == ((g == 0) ? dly_odd : dly_even)) && (m_p[g] || trig);
        @(posedge clk);
        #1;
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin m_d[i] = 0; m_h[i] = 0; m_s[i] = 0; end
            m_p[0] = 0; m_p[1] = 0; m_en = 0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                if (wr_en && wr_sel == 3'(i)) m_d[i] = wr_data;
                m_s[i] = ld[i % 2] ? he[i] : {m_s[i][14:0], 1'b0};
                m_h[i] = he[i];
            end
            for (int g = 0; g < 2; g++)
                m_p[g] = ld[g] ? 1'b0 : (m_p[g] || trig);
            m_en = trig ? 1'b1 : (line_start ? 1'b0 : m_en);
        end
        for (int i = 0; i < NP; i++) exp[i] = m_en & m_s[i][15];
        check(tag, pix_out, exp);
        hpos_lo = hpos_lo + 4'd1;
    endtask

    task automatic idle(input int n);
        wr_en = 0; line_start = 0;
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr(input int sel, input logic [15:0] d);
        wr_en = 1; wr_sel = 3'(sel); wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic new_line();
        line_start = 1; step(); line_start = 0;
    endtask

    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        for (int k = 0; k < 3; k++) step();
        rst_n = 1;
        idle(2);

        // Sweep all odd delays against several even delays (R4 main path).
        for (int od = 0; od < 16; od++) begin
            for (int ei = 0; ei < 4; ei++) begin
                dly_odd = 4'(od); dly_even = 4'(ei * 5);
                tag = "R7"; new_line();
                tag = "R2";
                for (int p = 1; p < NP; p++)
                    wr(p, 16'(32'hA5C3 ^ (p * 32'h1357) ^ (od << 4) ^ (ei << 9)));
                tag = "R3"; wr(0, 16'(32'h5A3C ^ (od * 32'h0101) ^ ei));
                tag = "R4"; idle(34);
            end
        end

        // R5: groups follow separate delays, changed mid-line.
        tag = "R5";
        dly_odd = 4'd3; dly_even = 4'd11;
        for (int p = 1; p < NP; p++) wr(p, 16'(32'hF00F >> p));
        wr(0, 16'hC3A5);
        idle(10);
        dly_even = 4'd2;
        idle(30);

        // R6: MSB-first order and zero fill after the word.
        tag = "R6";
        dly_odd = hpos_lo + 4'd2; dly_even = hpos_lo + 4'd2;
        for (int p = 1; p < NP; p++) wr(p, 16'h8001);
        wr(0, 16'h8001);
        idle(40);

        // R2: non-trigger writes leave held words alone before transfer.
        tag = "R2";
        dly_odd = hpos_lo + 4'd8; dly_even = hpos_lo + 4'd9;
        wr(0, 16'hFFFF);
        for (int p = 0; p < 5; p++) wr(1 + p, 16'h0000);
        idle(20);

        // R8: chase the delays so no match occurs; held words survive.
        tag = "R8";
        for (int p = 1; p < NP; p++) wr(p, 16'(32'h6996 + p));
        wr(0, 16'h9669);
        for (int k = 0; k < 40; k++) begin
            dly_odd = hpos_lo + 4'd8; dly_even = hpos_lo + 4'd7;
            step();
        end
        dly_odd = hpos_lo + 4'd4; dly_even = hpos_lo + 4'd6;
        idle(24);

        // R9: trigger on the matching cycle loads at once.
        tag = "R9";
        dly_odd = hpos_lo; dly_even = hpos_lo;
        wr(0, 16'hB00B);
        idle(20);

        // R7: line start together with trigger leaves outputs enabled.
        tag = "R7";
        dly_odd = hpos_lo + 4'd1; dly_even = hpos_lo + 4'd1;
        line_start = 1; wr(0, 16'hFFFF); line_start = 0;
        idle(6);
        new_line();
        wr(2, 16'hFFFF);
        idle(18);

        // R1: reset in the middle of activity.
        tag = "R1";
        dly_odd = hpos_lo + 4'd1;
        wr(0, 16'hFFFF);
        rst_n = 0; step(); step(); rst_n = 1;
        idle(18);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule